// File: doc/BRIEF.md
# Decimal-Capable 8-bit ALU with Flag Updates

This block is the arithmetic and logic datapath of a small accumulator-style processor. Each operation takes an operation code, a register operand `opa_i` (accumulator or index register), a memory or immediate operand `opm_i`, the incoming carry flag and the decimal-mode flag. It returns an 8-bit result with a result write-enable, plus next values for the negative (N), zero (Z), carry (C) and overflow (V) flags. Each flag has its own update-enable, so the surrounding processor changes only the flags that the operation defines.

Add and subtract have a packed-BCD decimal mode. In this mode only the result and C come from digit arithmetic. N, Z and V still describe the plain binary sum or difference. On subtract, C acts as an inverted borrow. The combinational core sits behind one register stage, so every accepted operation appears on the outputs one clock later. The register file, operand fetch and instruction decoding sit outside the block.

Top module: `bcd_alu8`

## Requirements
- R1: `op_i` selects 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right, 9 increment, 10 decrement, 11 compare, 12 bit test. An operation accepted with `valid_i` high appears on the outputs one cycle later with `valid_o` high. A cycle with `valid_i` low gives `valid_o`, `res_we_o` and all flag enables low in the next cycle, and reset gives the same state.
- R2: A binary add (decimal flag low) gives (opa + opm + carry) mod 256. C is set when the 9-bit sum is above 255. V is set when the signed sum lies outside -128..127. N and Z follow the result.
- R3: A binary subtract gives (opa - opm + carry - 1) mod 256. C is 1 when no borrow occurs, that is when 256 + opa - opm + carry - 1 is above 255. V is set on signed overflow of the same difference.
- R4: A decimal add works on 4-bit digits, low digit first. Each digit sum is opa digit + opm digit + the carry into that digit. The carry into the low digit is the carry input, and the carry into the high digit is 1 when the low sum is 10 or more. Each result digit is its sum mod 10, and C is set when the high digit sum is 10 or more.
- R5: A decimal subtract forms each digit as 10 + opa digit - opm digit. The carry input minus 1 is added to the low digit, and 1 is taken from the high digit when the low value is below 10. Each result digit is its value mod 10, and C is set when the high value is 10 or more. Decimal results are defined for valid BCD digit inputs.
- R6: In decimal add and subtract, N and Z come from the truncated binary result and V from binary signed overflow, not from the decimal result.
- R7: The shifts and rotates act on opa and update N, Z and C. A left shift puts bit 7 into C and a right shift puts bit 0 into C. Rotates fill the freed bit (bit 0 on a left rotate, bit 7 on a right rotate) with the incoming carry, and plain shifts fill it with 0.
- R8: Increment and decrement act on opa and wrap modulo 256. They update only N and Z, with C and V enables low.
- R9: AND, OR and XOR write opa op opm to the result and update only N and Z. For every result-writing operation other than add and subtract, N is result bit 7 and Z is set when the result is 0.
- R10: Compare sets C when opa >= opm (unsigned) and takes N and Z from (opa - opm) mod 256. It does not assert `res_we_o` or the V enable.
- R11: Bit test sets Z when (opa AND opm) is 0, copies opm bit 7 into N and opm bit 6 into V, and does not assert `res_we_o` or the C enable.
- R12: Codes 13 to 15 assert no enable. Whenever the C enable is low, `c_o` equals the carry input of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Register operand |
| opm_i | input | 8 | Memory or immediate operand |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Decimal mode for add and subtract |
| valid_o | output | 1 | Registered result present |
| res_o | output | 8 | Result value |
| res_we_o | output | 1 | Result is to be written back |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| n_we_o | output | 1 | Update N |
| z_we_o | output | 1 | Update Z |
| c_we_o | output | 1 | Update C |
| v_we_o | output | 1 | Update V |

## Verification
The only internal state is the output register, so a wrong value shows at the ports in the cycle right after the operation is accepted. It shows up as a wrong result or flag, or as an enable that should be low but is high. A broken decimal digit chain shows only for operands whose low digit crosses 10 or whose high digit overflows. For that reason the decimal vectors cover carry into the high digit, borrow from the high digit, and the 99 + 1 wrap where Z must still follow the binary sum. A swapped flag enable shows most clearly on compare, bit test and increment, where one flag must stay untouched while the others change.

// File: rtl/bcd_alu8_pkg.sv
package bcd_alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/bcd_alu8_addsub.sv
module bcd_alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             sub_i,
  input  logic             carry_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] bin_o,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] m_eff;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] dec_res;
  logic [DIGITS:0]  dk; // per-digit carry (add) / no-borrow (sub)

  assign m_eff = sub_i ? ~m_i : m_i;
  assign sum   = {1'b0, a_i} + {1'b0, m_eff} + {{WIDTH{1'b0}}, carry_i};
  assign bin_o = sum[WIDTH-1:0];
  assign v_o   = (a_i[WIDTH-1] == m_eff[WIDTH-1]) && (sum[WIDTH-1] != a_i[WIDTH-1]);

  assign dk[0] = carry_i;
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] ad;
    logic [3:0] md;
    logic [5:0] s;
    assign ad = a_i[4*g +: 4];
    assign md = m_i[4*g +: 4];
    always_comb begin
      if (sub_i) s = 6'd10 + {2'b00, ad} - {2'b00, md} - {5'd0, ~dk[g]};
      else       s = {2'b00, ad} + {2'b00, md} + {5'd0, dk[g]};
    end
    assign dk[g+1]         = (s >= 6'd10);
    assign dec_res[4*g +: 4] = 4'(s % 6'd10);
  end

  assign res_o = dec_i ? dec_res : bin_o;
  assign c_o   = dec_i ? dk[DIGITS] : sum[WIDTH];
endmodule

// File: rtl/bcd_alu8_logic.sv
module bcd_alu8_logic
  import bcd_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  always_comb begin
    res_o = a_i & m_i;
    c_o   = carry_i;
    case (op_i)
      OP_OR:  res_o = a_i | m_i;
      OP_XOR: res_o = a_i ^ m_i;
      OP_SHL: begin res_o = {a_i[WIDTH-2:0], 1'b0};    c_o = a_i[WIDTH-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[WIDTH-1:1]};    c_o = a_i[0];       end
      OP_ROL: begin res_o = {a_i[WIDTH-2:0], carry_i}; c_o = a_i[WIDTH-1]; end
      OP_ROR: begin res_o = {carry_i, a_i[WIDTH-1:1]}; c_o = a_i[0];       end
      OP_INC: res_o = a_i + WIDTH'(1);
      OP_DEC: res_o = a_i - WIDTH'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu8_core.sv
module bcd_alu8_core
  import bcd_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             carry_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] res_o,
  output logic             res_we_o,
  output alu_flags_t       flags_o,
  output alu_flags_t       we_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] as_bin, as_res, lg_res, cmp_diff;
  logic             as_c, as_v, lg_c;

  assign op       = alu_op_e'(op_i);
  assign cmp_diff = a_i - m_i;

  bcd_alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .m_i(m_i), .sub_i(op == OP_SBC), .carry_i(carry_i), .dec_i(dec_i),
    .bin_o(as_bin), .res_o(as_res), .c_o(as_c), .v_o(as_v)
  );

  bcd_alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i(op), .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .res_o(lg_res), .c_o(lg_c)
  );

  always_comb begin
    res_o    = lg_res;
    res_we_o = 1'b0;
    we_o     = '0;
    flags_o  = '{n: lg_res[MSB], z: (lg_res == '0), c: carry_i, v: 1'b0};
    case (op)
      OP_ADC, OP_SBC: begin
        res_o    = as_res;
        res_we_o = 1'b1;
        we_o     = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
        // N/Z/V follow the binary path even in decimal mode
        flags_o  = '{n: as_bin[MSB], z: (as_bin == '0), c: as_c, v: as_v};
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        res_we_o = 1'b1;
        we_o     = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_we_o  = 1'b1;
        we_o      = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
        flags_o.c = lg_c;
      end
      OP_CMP: begin
        res_o   = cmp_diff;
        we_o    = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
        flags_o = '{n: cmp_diff[MSB], z: (cmp_diff == '0), c: (a_i >= m_i), v: 1'b0};
      end
      OP_BIT: begin
        we_o    = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
        flags_o = '{n: m_i[MSB], z: (lg_res == '0), c: carry_i, v: m_i[MSB-1]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu8.sv
module bcd_alu8
  import bcd_alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opm_i,
  input  logic             carry_i,
  input  logic             dec_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] res_o,
  output logic             res_we_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o,
  output logic             n_we_o,
  output logic             z_we_o,
  output logic             c_we_o,
  output logic             v_we_o
);
  logic [WIDTH-1:0] core_res, res_q;
  logic             core_res_we, res_we_q, valid_q;
  alu_flags_t       core_flags, core_we, flags_q, we_q;

  bcd_alu8_core #(.WIDTH(WIDTH)) u_core (
    .op_i(op_i), .a_i(opa_i), .m_i(opm_i), .carry_i(carry_i), .dec_i(dec_i),
    .res_o(core_res), .res_we_o(core_res_we), .flags_o(core_flags), .we_o(core_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      res_q    <= '0;
      res_we_q <= 1'b0;
      flags_q  <= '0;
      we_q     <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q    <= core_res;
        res_we_q <= core_res_we;
        flags_q  <= core_flags;
        we_q     <= core_we;
      end else begin
        res_we_q <= 1'b0;
        we_q     <= '0;
      end
    end
  end

  assign valid_o  = valid_q;
  assign res_o    = res_q;
  assign res_we_o = res_we_q;
  assign n_o      = flags_q.n;
  assign z_o      = flags_q.z;
  assign c_o      = flags_q.c;
  assign v_o      = flags_q.v;
  assign n_we_o   = we_q.n;
  assign z_we_o   = we_q.z;
  assign c_we_o   = we_q.c;
  assign v_we_o   = we_q.v;
endmodule

// File: rtl/bcd_alu8_chk.sv
module bcd_alu8_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opm_i,
  input logic             carry_i,
  input logic             dec_i,
  input logic             valid_o,
  input logic [WIDTH-1:0] res_o,
  input logic             res_we_o,
  input logic             n_o,
  input logic             z_o,
  input logic             c_o,
  input logic             v_o,
  input logic             n_we_o,
  input logic             z_we_o,
  input logic             c_we_o,
  input logic             v_we_o
);
  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !res_we_o && !n_we_o && !z_we_o && !c_we_o && !v_we_o);

  p_bin_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd0 && !dec_i |=>
      res_o == $past(opa_i + opm_i + WIDTH'(carry_i)));

  p_incdec_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd9 || op_i == 4'd10) |=>
      n_we_o && z_we_o && !c_we_o && !v_we_o && c_o == $past(carry_i));

  p_nz_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 4'd2 && op_i <= 4'd10 |=>
      z_o == (res_o == '0) && n_o == res_o[WIDTH-1]);

  p_cmp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd11 |=>
      !res_we_o && c_we_o && !v_we_o && c_o == $past(opa_i >= opm_i));

  p_bit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd12 |=>
      !res_we_o && !c_we_o && n_o == $past(opm_i[WIDTH-1]) && v_o == $past(opm_i[WIDTH-2]));

  p_undef_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 4'd13 |=>
      !res_we_o && !n_we_o && !z_we_o && !c_we_o && !v_we_o && c_o == $past(carry_i));

  logic unused_dec;
  assign unused_dec = dec_i;
endmodule

bind bcd_alu8 bcd_alu8_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .opa_i(opa_i),
  .opm_i(opm_i), .carry_i(carry_i), .dec_i(dec_i), .valid_o(valid_o), .res_o(res_o),
  .res_we_o(res_we_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .n_we_o(n_we_o),
  .z_we_o(z_we_o), .c_we_o(c_we_o), .v_we_o(v_we_o)
);

// File: tb/bcd_alu8_tb_top.sv
`timescale 1ns/1ps
module bcd_alu8_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] opa_i = '0, opm_i = '0;
  logic       carry_i = 1'b0, dec_i = 1'b0;
  logic       valid_o, res_we_o, n_o, z_o, c_o, v_o, n_we_o, z_we_o, c_we_o, v_we_o;
  logic [7:0] res_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [16:0] exp;
    logic [16:0] mask;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk_i = ~clk_i;

  bcd_alu8 dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .opa_i(opa_i),
    .opm_i(opm_i), .carry_i(carry_i), .dec_i(dec_i), .valid_o(valid_o), .res_o(res_o),
    .res_we_o(res_we_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .n_we_o(n_we_o),
    .z_we_o(z_we_o), .c_we_o(c_we_o), .v_we_o(v_we_o)
  );

  function automatic int sx(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packed: {res_we, res[7:0], n_we, z_we, c_we, v_we, n, z, c, v}
  task automatic drive(input int op, input int a, input int m, input bit cin,
                       input bit dec, input string tag);
    int res = 0, t = 0, sv = 0, lo, hi, nz = 0;
    bit rwe = 0, nwe = 0, zwe = 0, cwe = 0, vwe = 0, n = 0, z = 0, c = cin, v = 0;
    item_t it;
    case (op)
      0, 1: begin
        if (op == 0) begin
          t = a + m + cin; sv = sx(a) + sx(m) + cin;
        end else begin
          t = 256 + a - m + cin - 1; sv = sx(a) - sx(m) + cin - 1;
        end
        nz = t & 255; c = t > 255; v = (sv < -128) || (sv > 127); res = nz;
        if (dec && op == 0) begin
          lo = (a & 15) + (m & 15) + cin;
          hi = (a >> 4) + (m >> 4) + ((lo >= 10) ? 1 : 0);
          res = ((hi % 10) << 4) | (lo % 10); c = hi > 9;
        end else if (dec) begin
          lo = 10 + (a & 15) - (m & 15) + cin - 1;
          hi = 10 + (a >> 4) - (m >> 4) - ((lo < 10) ? 1 : 0);
          res = ((hi % 10) << 4) | (lo % 10); c = hi >= 10;
        end
        rwe = 1; nwe = 1; zwe = 1; cwe = 1; vwe = 1;
      end
      2, 3, 4, 9, 10: begin
        case (op)
          2: res = a & m;
          3: res = a | m;
          4: res = a ^ m;
          9: res = (a + 1) & 255;
          default: res = (a + 255) & 255;
        endcase
        nz = res; rwe = 1; nwe = 1; zwe = 1;
      end
      5, 6, 7, 8: begin
        case (op)
          5: begin res = (a << 1) & 255; c = a[7]; end
          6: begin res = a >> 1; c = a[0]; end
          7: begin res = ((a << 1) & 255) | cin; c = a[7]; end
          default: begin res = (a >> 1) | (cin << 7); c = a[0]; end
        endcase
        nz = res; rwe = 1; nwe = 1; zwe = 1; cwe = 1;
      end
      11: begin
        nz = (a - m + 256) & 255; c = a >= m; nwe = 1; zwe = 1; cwe = 1;
      end
      default: ;
    endcase
    n = nz[7]; z = (nz == 0);
    if (op == 12) begin
      z = ((a & m) == 0); n = m[7]; v = m[6]; nwe = 1; zwe = 1; vwe = 1;
    end
    it.exp  = {rwe, 8'(res), nwe, zwe, cwe, vwe, n, z, c, v};
    it.mask = {1'b1, {8{rwe}}, 4'hF, nwe, zwe, 1'b1, vwe};
    it.tag  = tag;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 4'(op); opa_i = 8'(a); opm_i = 8'(m);
    carry_i = cin; dec_i = dec;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk_i);
    #1;
    if (valid_o) begin
      logic [16:0] act;
      item_t it;
      act = {res_we_o, res_o, n_we_o, z_we_o, c_we_o, v_we_o, n_o, z_o, c_o, v_o};
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected valid_o", act, 0);
      end else begin
        it = q.pop_front();
        check(((act ^ it.exp) & it.mask) == '0, it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lf;
    lf = 32'h1d2c;
    repeat (3) @(negedge clk_i);
    check(!valid_o && !res_we_o && !c_we_o && !n_we_o, "R1 reset state", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!valid_o, "R1 idle after reset", valid_o, 0);

    drive(0, 8'h50, 8'h50, 0, 0, "R2 add signed overflow");
    drive(0, 8'hFF, 8'h01, 0, 0, "R2 add carry out zero");
    drive(0, 8'h7F, 8'h00, 1, 0, "R2 add carry in overflow");
    drive(1, 8'h50, 8'hF0, 1, 0, "R3 sub borrow");
    drive(1, 8'h00, 8'h01, 1, 0, "R3 sub wrap");
    drive(1, 8'h05, 8'h05, 0, 0, "R3 sub carry-in borrow");
    drive(1, 8'h80, 8'h01, 1, 0, "R3 sub signed overflow");
    drive(0, 8'h58, 8'h46, 1, 1, "R4 dec add digit carry");
    drive(0, 8'h12, 8'h34, 0, 1, "R4 dec add plain");
    drive(0, 8'h99, 8'h01, 0, 1, "R6 dec add wrap z binary");
    drive(1, 8'h46, 8'h12, 1, 1, "R5 dec sub plain");
    drive(1, 8'h12, 8'h21, 1, 1, "R5 dec sub high borrow");
    drive(1, 8'h20, 8'h01, 0, 1, "R5 dec sub low borrow");
    drive(1, 8'h00, 8'h00, 0, 1, "R6 dec sub flags binary");
    drive(5, 8'h81, 0, 1, 0, "R7 shift left");
    drive(6, 8'h01, 0, 1, 0, "R7 shift right zero");
    drive(7, 8'h40, 0, 1, 0, "R7 rotate left");
    drive(8, 8'h02, 0, 1, 0, "R7 rotate right");
    drive(8, 8'h03, 0, 0, 0, "R7 rotate right no carry");
    drive(9, 8'hFF, 0, 1, 0, "R8 increment wrap");
    drive(10, 8'h00, 0, 0, 0, "R8 decrement wrap");
    drive(2, 8'hF0, 8'h0F, 1, 0, "R9 and zero");
    drive(3, 8'h80, 8'h01, 0, 0, "R9 or");
    drive(4, 8'hAA, 8'hFF, 0, 0, "R9 xor");
    drive(11, 8'h40, 8'h40, 0, 0, "R10 compare equal");
    drive(11, 8'h10, 8'h20, 1, 0, "R10 compare less");
    drive(11, 8'hF0, 8'h20, 0, 0, "R10 compare greater");
    drive(12, 8'h01, 8'hC0, 1, 0, "R11 bit test zero");
    drive(12, 8'h41, 8'h41, 0, 0, "R11 bit test nonzero");
    drive(13, 8'h12, 8'h34, 1, 0, "R12 undefined code 13");
    drive(15, 8'h12, 8'h34, 0, 1, "R12 undefined code 15");
    idle(2);
    check(!valid_o && !res_we_o, "R1 gap clears valid", valid_o, 0);
    for (int i = 0; i < 40; i++) begin
      int a, m, d, op;
      lf = (lf << 1) ^ ((lf[15] ^ lf[13] ^ lf[12] ^ lf[10]) ? 1 : 0);
      lf = lf & 16'hFFFF;
      op = i % 2;
      d  = (i / 2) % 2;
      if (d == 1) begin
        a = ((lf % 10) << 4) | ((lf / 10) % 10);
        m = (((lf / 100) % 10) << 4) | ((lf / 1000) % 10);
      end else begin
        a = lf & 255;
        m = (lf >> 8) & 255;
      end
      drive(op, a, m, lf[3], d[0], d ? "R4 R5 decimal sweep" : "R2 R3 binary sweep");
    end
    idle(3);
    check(q.size() == 0, "R1 all results delivered", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule